// File: doc/BRIEF.md
# Interrupt Level Mask Gate

This block holds the 5-bit interrupt priority mask of a CPU and decides whether the single pending interrupt request may be taken. Levels run from 0, the most urgent, to 31, the least urgent. A request is taken only when its level is numerically below the held mask.

Software changes the mask through a one-cycle write strobe. A guard limits which values software may store. While the held mask is in the upper half (16 to 31), software cannot move it into the lower half. A write of 0 to 15 is then stored with 16 added. While the mask is in the lower half, any value may be written.

A separate hardware load path, such as the one exception entry would drive, stores any value without the guard. It wins over a software write in the same cycle. The held mask is always visible on a read port.

Top module: `irq_lvl_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the mask is set to 15, and `mask_q` reads 15 after that edge.
- R2: When the held mask is 0 to 15, a software write (`sw_we` high, `hw_ld` low) stores `sw_wdata` unchanged. The new value appears on `mask_q` after the next clock edge.
- R3: When the held mask is 16 to 31, a software write of 16 to 31 is stored unchanged.
- R4: When the held mask is 16 to 31, a software write of a value v in 0 to 15 stores v+16. This is the same as forcing bit 4 to 1.
- R5: A hardware load (`hw_ld` high) stores `hw_ldata` unchanged, whatever value is held.
- R6: When `hw_ld` and `sw_we` are both high in one cycle, only `hw_ldata` is stored and `sw_wdata` is ignored.
- R7: `req_accept` is high exactly when `req_vld` is high and `req_lvl` is numerically less than `mask_q`. This is combinational, in the same cycle, and an equal level is refused.
- R8: `req_accept` is low whenever `req_vld` is low, whatever `req_lvl` and the mask hold.
- R9: In a cycle with neither `sw_we` nor `hw_ld` high, the held mask does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 5 | Software write value, subject to the guard |
| hw_ld | input | 1 | Hardware load strobe, has priority |
| hw_ldata | input | 5 | Hardware load value, unguarded |
| mask_q | output | 5 | Currently held mask |
| req_vld | input | 1 | A request is pending |
| req_lvl | input | 5 | Level of the pending request |
| req_accept | output | 1 | Pending request passes the mask |

## Verification
The write guard is swept over every pair of held value (0 to 31, placed by hardware load) and written value (0 to 31). This separates unchanged stores below the boundary, unchanged stores above it, and the +16 remap exactly at the 15/16 edges.

The comparator is swept over every mask and request level with `req_vld` both high and low. This separates the strict less-than from an off-by-one or inverted compare and shows the valid qualifier.

Concurrent strobes and idle cycles are tried with values chosen to differ in every bit. This shows the load priority and the hold behaviour. A mid-run reset shows the reset value.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    // Default width of a priority level and the mask value after reset.
    localparam int DEF_LVL_W     = 5;
    localparam int DEF_RESET_LVL = 15;

    // Which path updates the mask in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SW   = 2'd1,
        SRC_HW   = 2'd2
    } wr_src_e;

    // Picks the update source. The hardware load path wins over software.
    function automatic wr_src_e pick_src(input logic sw_we, input logic hw_ld);
        if (hw_ld)
            return SRC_HW;
        else if (sw_we)
            return SRC_SW;
        else
            return SRC_NONE;
    endfunction

endpackage

// File: rtl/lvl_wr_filter.sv
// Applies the software write guard.
// An upper-half held value pins the top bit of the stored value to 1.
module lvl_wr_filter
    import irq_lvl_pkg::*;
#(
    parameter int LVL_W = DEF_LVL_W
) (
    input  logic [LVL_W-1:0] held,
    input  logic [LVL_W-1:0] wdata,
    output logic [LVL_W-1:0] guarded
);
    localparam int MSB = LVL_W - 1;

    logic locked;

    always_comb begin
        locked  = held[MSB];
        guarded = wdata;
        // Adding half the range to a lower-half value only sets the top bit.
        if (locked)
            guarded[MSB] = 1'b1;
    end
endmodule

// File: rtl/lvl_mask_reg.sv
// Mask storage with source selection and synchronous reset.
module lvl_mask_reg
    import irq_lvl_pkg::*;
#(
    parameter int LVL_W     = DEF_LVL_W,
    parameter int RESET_LVL = DEF_RESET_LVL
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_src_e          src,
    input  logic [LVL_W-1:0] sw_val,
    input  logic [LVL_W-1:0] hw_val,
    output logic [LVL_W-1:0] q
);
    localparam logic [LVL_W-1:0] RST_V = LVL_W'(RESET_LVL);

    logic [LVL_W-1:0] d;

    always_comb begin
        unique case (src)
            SRC_HW:  d = hw_val;
            SRC_SW:  d = sw_val;
            default: d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_V;
        else
            q <= d;
    end
endmodule

// File: rtl/lvl_accept_cmp.sv
// Decides whether the pending request passes the mask.
// A lower number means a more urgent request.
module lvl_accept_cmp
    import irq_lvl_pkg::*;
#(
    parameter int LVL_W = DEF_LVL_W
) (
    input  logic             vld,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] mask,
    output logic             accept
);
    always_comb begin
        accept = vld && (lvl < mask);
    end
endmodule

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate
    import irq_lvl_pkg::*;
#(
    parameter int LVL_W     = DEF_LVL_W,
    parameter int RESET_LVL = DEF_RESET_LVL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [LVL_W-1:0] sw_wdata,
    input  logic             hw_ld,
    input  logic [LVL_W-1:0] hw_ldata,
    output logic [LVL_W-1:0] mask_q,
    input  logic             req_vld,
    input  logic [LVL_W-1:0] req_lvl,
    output logic             req_accept
);
    wr_src_e          src;
    logic [LVL_W-1:0] sw_guarded;

    always_comb src = pick_src(sw_we, hw_ld);

    lvl_wr_filter #(.LVL_W(LVL_W)) filt_i (
        .held    (mask_q),
        .wdata   (sw_wdata),
        .guarded (sw_guarded)
    );

    lvl_mask_reg #(.LVL_W(LVL_W), .RESET_LVL(RESET_LVL)) reg_i (
        .clk    (clk),
        .rst    (rst),
        .src    (src),
        .sw_val (sw_guarded),
        .hw_val (hw_ldata),
        .q      (mask_q)
    );

    lvl_accept_cmp #(.LVL_W(LVL_W)) cmp_i (
        .vld    (req_vld),
        .lvl    (req_lvl),
        .mask   (mask_q),
        .accept (req_accept)
    );
endmodule

// File: rtl/irq_lvl_gate_chk.sv
module irq_lvl_gate_chk #(
    parameter int LVL_W     = 5,
    parameter int RESET_LVL = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_we,
    input logic [LVL_W-1:0] sw_wdata,
    input logic             hw_ld,
    input logic [LVL_W-1:0] hw_ldata,
    input logic [LVL_W-1:0] mask_q,
    input logic             req_vld,
    input logic [LVL_W-1:0] req_lvl,
    input logic             req_accept
);
    localparam int MSB = LVL_W - 1;

    AST_RESET_VAL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mask_q == LVL_W'(RESET_LVL)); // R1

    AST_SW_OPEN: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !hw_ld && !mask_q[MSB]) |=> mask_q == $past(sw_wdata)); // R2

    AST_SW_LOCKED_LOW: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !hw_ld && mask_q[MSB]) |=> mask_q[MSB-1:0] == $past(sw_wdata[MSB-1:0])); // R3

    AST_SW_LOCKED_TOP: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !hw_ld && mask_q[MSB]) |=> mask_q[MSB]); // R4

    AST_HW_LOAD: assert property (@(posedge clk) disable iff (rst)
        hw_ld |=> mask_q == $past(hw_ldata)); // R5

    AST_HW_PRIO: assert property (@(posedge clk) disable iff (rst)
        (hw_ld && sw_we) |=> mask_q == $past(hw_ldata)); // R6

    AST_ACCEPT_RULE: assert property (@(posedge clk) disable iff (rst)
        req_accept == (req_vld && (req_lvl < mask_q))); // R7

    AST_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_vld |-> !req_accept); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && !hw_ld) |=> $stable(mask_q)); // R9
endmodule

bind irq_lvl_gate irq_lvl_gate_chk #(.LVL_W(LVL_W), .RESET_LVL(RESET_LVL)) chk_i (.*);

// File: tb/irq_lvl_gate_tb_top.sv
`timescale 1ns/1ps
module irq_lvl_gate_tb_top;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sw_we = 1'b0;
    logic [W-1:0] sw_wdata = '0;
    logic         hw_ld = 1'b0;
    logic [W-1:0] hw_ldata = '0;
    logic [W-1:0] mask_q;
    logic         req_vld = 1'b0;
    logic [W-1:0] req_lvl = '0;
    logic         req_accept;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    irq_lvl_gate dut_i (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .hw_ld(hw_ld), .hw_ldata(hw_ldata), .mask_q(mask_q),
        .req_vld(req_vld), .req_lvl(req_lvl), .req_accept(req_accept)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of strobes. The register updates at the posedge in between.
    task automatic cycle(input bit we, input int wd, input bit ld, input int ld_d);
        @(negedge clk);
        sw_we = we; sw_wdata = W'(wd); hw_ld = ld; hw_ldata = W'(ld_d);
        @(negedge clk);
        sw_we = 1'b0; hw_ld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk(mask_q == 5'd15, "R1 reset value", int'(mask_q), 15);

        // Guard sweep: every held value against every written value.
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 32; w++) begin
                int exp;
                cycle(1'b0, 0, 1'b1, s);
                chk(mask_q == W'(s), "R5 hw load", int'(mask_q), s);
                cycle(1'b1, w, 1'b0, 0);
                exp = (s >= 16 && w < 16) ? w + 16 : w;
                if (s < 16)
                    chk(mask_q == W'(exp), "R2 open write", int'(mask_q), exp);
                else if (w >= 16)
                    chk(mask_q == W'(exp), "R3 locked high write", int'(mask_q), exp);
                else
                    chk(mask_q == W'(exp), "R4 locked remap", int'(mask_q), exp);
            end
        end

        // Priority of the hardware load: values that differ in every bit.
        for (int k = 0; k < 32; k++) begin
            cycle(1'b1, 31 - k, 1'b1, k);
            chk(mask_q == W'(k), "R6 hw over sw", int'(mask_q), k);
        end

        // Hold with no strobe, from both halves.
        for (int k = 0; k < 32; k += 5) begin
            cycle(1'b0, 0, 1'b1, k);
            cycle(1'b0, 31 - k, 1'b0, 31 - k);
            cycle(1'b0, 0, 1'b0, 0);
            chk(mask_q == W'(k), "R9 hold", int'(mask_q), k);
        end

        // Comparator sweep over every mask, level and valid setting.
        for (int m = 0; m < 32; m++) begin
            cycle(1'b0, 0, 1'b1, m);
            for (int l = 0; l < 32; l++) begin
                for (int v = 0; v < 2; v++) begin
                    bit exp_a;
                    @(negedge clk);
                    req_vld = v[0]; req_lvl = W'(l);
                    #1;
                    exp_a = (v == 1) && (l < m);
                    if (v == 1)
                        chk(req_accept == exp_a, "R7 accept compare", int'(req_accept), int'(exp_a));
                    else
                        chk(req_accept == 1'b0, "R8 no request", int'(req_accept), 0);
                end
            end
        end
        req_vld = 1'b0;

        // Reset mid-run from a locked value.
        cycle(1'b0, 0, 1'b1, 28);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 chk(mask_q == 5'd15, "R1 reset from locked", int'(mask_q), 15);
        cycle(1'b1, 3, 1'b0, 0);
        chk(mask_q == 5'd3, "R2 open after reset", int'(mask_q), 3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule